// File: doc/BRIEF.md
# Receive Frame Wrapping FIFO

This block takes Ethernet frames from an upstream byte stream and packs each one into a single byte-addressed receive store. Every frame is stored inside a wrapper: a constant marker word, an info word that carries the stored length and an OK status, the frame bytes, zero fill up to the 60-byte minimum, a CRC-32 word, and zero bytes that bring the frame to a 4-byte boundary. A frame becomes visible to the host only once its whole wrapper is in the store.

The host drains the store through a single 32-bit read port. The current word is always present on `rd_data`. A pulse on `rd_en` consumes it. The block tracks which part of the wrapper it is in, takes the body length from the info word, and counts down through the body. When the last word of a frame is consumed, the pending-frame count drops by one. A write of zero to the count register discards everything in the store. Each stored frame also sets a sticky interrupt flag.

Top module: `rxw_fifo`

## Requirements
- R1: Between frames, `in_ready` is 1 exactly when `rx_en` is 1 and at least ROOM_MIN (1532) bytes of the store are free. Once the first byte of a frame is taken, `in_ready` stays 1 until its last byte.
- R2: A byte offered while `in_ready` is 0 is not taken. Such a byte stores nothing and leaves `pend_cnt` unchanged.
- R3: A frame of n < 60 bytes is extended with 60−n zero bytes. Let p be the padded length: p = max(n, 60).
- R4: Each stored frame is laid out in this order: first the MAGIC word, then the info word {STAT_OK in bits 31:16, p+4 in bits 15:0}, then the n data bytes, the zero fill, the CRC word, and finally (4 − p mod 4) mod 4 zero bytes.
- R5: The CRC word is a reflected CRC-32 over the data bytes and the zero fill. It uses polynomial 0xEDB88320, starts from 0xFFFFFFFF, and stores the complement of the final value.
- R6: Every word is little-endian. The byte at the lowest store address appears in `rd_data[7:0]`.
- R7: `pend_cnt` goes up by one and `rx_irq` goes to 1 on the clock edge that comes (60−n if n<60, else 0) + a + 13 edges after the edge that takes the last byte, where a is the alignment fill from R4.
- R8: `irq_clr` clears `rx_irq`. If a frame is stored in the same cycle, the set wins.
- R9: When `pend_cnt` is nonzero, `rd_data` shows the current word and `rd_en` consumes it. After the info word, the block consumes (p+4) rounded up to a multiple of 4 bytes, four per read. The edge that consumes the last of these decrements `pend_cnt`, and the next word shown is the MAGIC word of the following frame.
- R10: While `pend_cnt` is 0, `rd_data` reads 0 and `rd_en` consumes nothing.
- R11: A `cnt_wr` with `cnt_wdata` = 0 empties the store and clears `pend_cnt` and the read position. A `cnt_wr` with any other value has no effect.
- R12: A frame that crosses the end of the store wraps to address 0 and reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| rd_en | input | 1 | Consume the current read word |
| rd_data | output | 32 | Current read word |
| cnt_wr | input | 1 | Write strobe for the frame-count register |
| cnt_wdata | input | CNT_W | Value written to the frame-count register |
| pend_cnt | output | CNT_W | Number of complete frames waiting |
| irq_clr | input | 1 | Clears the receive interrupt flag |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
`in_ready` and `rd_data` are combinational from state, so the bench reads them at the falling edge, after it has set the inputs for the next rising edge. For each frame, the bench computes from R7 the exact edge on which `pend_cnt` rises. It checks the count unchanged one edge earlier and incremented right after that edge. A consumed word leaves `rd_data` on the same rising edge that pops it, so each word is compared at the falling edge before its pop. The decrement of `pend_cnt` is checked at the falling edge right after the final pop.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [2:0] {
    W_IDLE, W_DATA, W_PAD, W_CRC, W_ALIGN, W_HDR, W_DROP
  } wr_state_e;

  typedef enum logic [1:0] {
    R_MAGIC, R_INFO, R_BODY
  } rd_pos_e;

  // One byte of reflected CRC-32, low bit first
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [15:0] up4(input logic [15:0] x);
    logic [15:0] s;
    s = x + 16'd3;
    return {s[15:2], 2'b00};
  endfunction

endpackage

// File: rtl/rxw_store.sv
module rxw_store #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-3:0] rword,
  output logic [31:0]   rdata
);
  localparam int WORDS = 1 << (AW - 2);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && (waddr[1:0] == 2'(l))) lane_mem[waddr[AW-1:2]] <= wdata;
    end
    assign rdata[8*l +: 8] = lane_mem[rword];
  end
endmodule

// File: rtl/rxw_writer.sv
module rxw_writer
  import rxw_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          MIN_LEN  = 60,
  parameter int          ROOM_MIN = 1532,
  parameter logic [31:0] MAGIC    = 32'h5AA5_0143,
  parameter logic [15:0] STAT_OK  = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          flush,
  input  logic [AW:0]   free,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          commit,
  output logic [AW:0]   wr_base
);
  localparam int PW = AW + 1;

  wr_state_e   st_q, st_d;
  logic [15:0] len_q, len_d;
  logic [2:0]  k_q, k_d;
  logic [31:0] crc_q, crc_d;
  logic [PW-1:0] base_q, base_d;

  logic        take, mid;
  logic [PW-1:0] body_addr, addr_full;
  logic [31:0] crc_inv;
  logic [63:0] hdr;

  assign in_ready  = (st_q == W_IDLE) ? (rx_en && (free >= PW'(ROOM_MIN)))
                                      : (st_q == W_DATA || st_q == W_DROP);
  assign take      = in_valid && in_ready;
  assign body_addr = base_q + PW'(8) + PW'(len_q);
  assign crc_inv   = ~crc_q;
  assign hdr       = {STAT_OK, len_q + 16'd4, MAGIC};
  assign mid       = (st_q == W_DATA) || (st_q == W_DROP) || (st_q == W_IDLE && take);
  assign mem_addr  = addr_full[AW-1:0];
  assign wr_base   = base_q;

  always_comb begin
    st_d = st_q; len_d = len_q; k_d = k_q; crc_d = crc_q; base_d = base_q;
    mem_we = 1'b0; addr_full = body_addr; mem_wdata = 8'h00; commit = 1'b0;
    case (st_q)
      W_IDLE, W_DATA: if (take) begin
        mem_we = 1'b1; mem_wdata = in_data;
        len_d  = len_q + 16'd1;
        crc_d  = crc_step(crc_q, in_data);
        k_d    = 3'd0;
        if (in_last) st_d = (len_q + 16'd1 < 16'(MIN_LEN)) ? W_PAD : W_CRC;
        else         st_d = W_DATA;
      end
      W_PAD: begin
        mem_we = 1'b1;
        len_d  = len_q + 16'd1;
        crc_d  = crc_step(crc_q, 8'h00);
        if (len_q + 16'd1 >= 16'(MIN_LEN)) st_d = W_CRC;
      end
      W_CRC: begin
        mem_we    = 1'b1;
        addr_full = body_addr + PW'(k_q);
        mem_wdata = crc_inv[{k_q[1:0], 3'b000} +: 8];
        k_d       = k_q + 3'd1;
        if (k_q == 3'd3) begin st_d = W_ALIGN; k_d = 3'd0; end
      end
      W_ALIGN: begin
        if (len_q[1:0] + k_q[1:0] == 2'b00) begin
          st_d = W_HDR; k_d = 3'd0;
        end else begin
          mem_we    = 1'b1;
          addr_full = body_addr + PW'(4) + PW'(k_q);
          k_d       = k_q + 3'd1;
        end
      end
      W_HDR: begin
        mem_we    = 1'b1;
        addr_full = base_q + PW'(k_q);
        mem_wdata = hdr[{k_q, 3'b000} +: 8];
        k_d       = k_q + 3'd1;
        if (k_q == 3'd7) begin
          commit = 1'b1;
          base_d = base_q + PW'(12) + PW'(up4(len_q));
          len_d  = 16'd0;
          crc_d  = 32'hFFFF_FFFF;
          st_d   = W_IDLE;
        end
      end
      W_DROP: if (take && in_last) st_d = W_IDLE;
      default: st_d = W_IDLE;
    endcase
    if (flush) begin
      mem_we = 1'b0; commit = 1'b0;
      base_d = '0; len_d = 16'd0; k_d = 3'd0; crc_d = 32'hFFFF_FFFF;
      st_d   = (mid && !(take && in_last)) ? W_DROP : W_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; len_q <= 16'd0; k_q <= 3'd0;
      crc_q <= 32'hFFFF_FFFF; base_q <= '0;
    end else begin
      st_q <= st_d; len_q <= len_d; k_q <= k_d;
      crc_q <= crc_d; base_q <= base_d;
    end
  end

  // R3
  pad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == W_CRC) |-> (len_q >= 16'(MIN_LEN)));
  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_last && !flush) |=> in_ready);
endmodule

// File: rtl/rxw_reader.sv
module rxw_reader
  import rxw_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rd_en,
  input  logic          have_frame,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   rd_data,
  output logic [AW-3:0] rword,
  output logic [AW:0]   rd_ptr,
  output logic          frame_done
);
  localparam int PW = AW + 1;

  rd_pos_e       pos_q, pos_d;
  logic [15:0]   rem_q, rem_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          pop;

  assign pop     = rd_en && have_frame;
  assign rd_data = have_frame ? mem_rdata : 32'h0;
  assign rword   = ptr_q[AW-1:2];
  assign rd_ptr  = ptr_q;

  always_comb begin
    pos_d = pos_q; rem_d = rem_q; ptr_d = ptr_q; frame_done = 1'b0;
    if (pop) begin
      ptr_d = ptr_q + PW'(4);
      case (pos_q)
        R_MAGIC: pos_d = R_INFO;
        R_INFO: begin
          pos_d = R_BODY;
          rem_d = up4(mem_rdata[15:0]);
        end
        default: begin
          rem_d = rem_q - 16'd4;
          if (rem_q == 16'd4) begin
            pos_d = R_MAGIC;
            frame_done = 1'b1;
          end
        end
      endcase
    end
    if (flush) begin
      pos_d = R_MAGIC; rem_d = 16'd0; ptr_d = '0; frame_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= R_MAGIC; rem_q <= 16'd0; ptr_q <= '0;
    end else begin
      pos_q <= pos_d; rem_q <= rem_d; ptr_q <= ptr_d;
    end
  end

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !have_frame && !flush) |=> $stable(ptr_q));
  // R9
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (pos_q == R_MAGIC && ptr_q[1:0] == 2'b00));
endmodule

// File: rtl/rxw_fifo.sv
module rxw_fifo
  import rxw_pkg::*;
#(
  parameter int          DEPTH    = 4096,
  parameter int          CNT_W    = 8,
  parameter int          MIN_LEN  = 60,
  parameter int          ROOM_MIN = 1532,
  parameter logic [31:0] MAGIC    = 32'h5AA5_0143,
  parameter logic [15:0] STAT_OK  = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] pend_cnt,
  input  logic             irq_clr,
  output logic             rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          flush, commit, frame_done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [AW-3:0] rword;
  logic [31:0]   mem_rdata;
  logic [PW-1:0] wr_base, rd_ptr, used, free;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;

  assign flush    = cnt_wr && (cnt_wdata == '0);
  assign used     = wr_base - rd_ptr;
  assign free     = PW'(DEPTH) - used;
  assign pend_cnt = cnt_q;
  assign rx_irq   = irq_q;

  rxw_writer #(.AW(AW), .MIN_LEN(MIN_LEN), .ROOM_MIN(ROOM_MIN),
               .MAGIC(MAGIC), .STAT_OK(STAT_OK)) u_wr (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush), .free(free),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .commit(commit), .wr_base(wr_base)
  );

  rxw_store #(.AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .rword(rword), .rdata(mem_rdata)
  );

  rxw_reader #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_en(rd_en),
    .have_frame(cnt_q != '0), .mem_rdata(mem_rdata), .rd_data(rd_data),
    .rword(rword), .rd_ptr(rd_ptr), .frame_done(frame_done)
  );

  always_comb begin
    cnt_d = cnt_q + CNT_W'(commit) - CNT_W'(frame_done);
    if (flush) cnt_d = '0;
    irq_d = commit ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; irq_q <= irq_d;
    end
  end

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rx_irq);
  // R7
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !frame_done && !flush) |=> (pend_cnt == $past(pend_cnt) + CNT_W'(1)));
  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_cnt == '0));
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
endmodule

// File: tb/rxw_fifo_tb.sv
module rxw_fifo_tb;
  localparam logic [31:0] T_MAGIC = 32'h5AA5_0143;
  localparam logic [15:0] T_STAT  = 16'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, in_valid = 1'b0, in_last = 1'b0, rd_en = 1'b0;
  logic cnt_wr = 1'b0, irq_clr = 1'b0;
  logic [7:0] in_data = 8'h00, cnt_wdata = 8'h00;
  logic in_ready, rx_irq;
  logic [31:0] rd_data;
  logic [7:0] pend_cnt;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  int tot_q[$];

  always #5 clk = ~clk;

  rxw_fifo #(.MAGIC(T_MAGIC), .STAT_OK(T_STAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .rd_en(rd_en), .rd_data(rd_data), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .pend_cnt(pend_cnt), .irq_clr(irq_clr), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + (i >> 3)) & 8'hFF);
  endfunction

  function automatic logic [31:0] bench_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int j = 0; j < 8; j++) begin
      if ((r[0] ^ b[j]) == 1'b1) r = (r >> 1) ^ 32'hEDB8_8320;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic push_word(input logic [31:0] w);
    for (int j = 0; j < 4; j++) exp_q.push_back(w[8*j +: 8]);
  endtask

  task automatic model_frame(input int n, input int seed);
    int p, a;
    logic [31:0] c;
    p = (n < 60) ? 60 : n;
    a = (4 - p % 4) % 4;
    c = 32'hFFFF_FFFF;
    push_word(T_MAGIC);
    push_word({T_STAT, 16'(p + 4)});
    for (int i = 0; i < p; i++) begin
      logic [7:0] b;
      b = (i < n) ? pat(seed, i) : 8'h00;
      exp_q.push_back(b);
      c = bench_crc(c, b);
    end
    push_word(~c);
    for (int i = 0; i < a; i++) exp_q.push_back(8'h00);
    tot_q.push_back(8 + p + 4 + a);
  endtask

  task automatic send_frame(input int n, input int seed);
    int p, a, d;
    logic [7:0] c0;
    c0 = pend_cnt;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(seed, i); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    p = (n < 60) ? 60 : n;
    a = (4 - p % 4) % 4;
    d = ((n < 60) ? 60 - n : 0) + a + 13;
    repeat (d - 1) @(posedge clk);
    @(negedge clk);
    chk("R7 count not yet raised", 32'(pend_cnt), 32'(c0));
    @(posedge clk);
    @(negedge clk);
    chk("R7 count raised", 32'(pend_cnt), 32'(c0) + 1);
    chk("R7 irq set", 32'(rx_irq), 32'd1);
    model_frame(n, seed);
  endtask

  task automatic read_frame();
    int tot;
    logic [7:0] c0;
    logic [31:0] w;
    tot = tot_q.pop_front();
    c0 = pend_cnt;
    for (int k = 0; k < tot / 4; k++) begin
      @(negedge clk);
      rd_en = 1'b1;
      w = {exp_q[3], exp_q[2], exp_q[1], exp_q[0]};
      for (int j = 0; j < 4; j++) void'(exp_q.pop_front());
      if (k == 0)      chk("R4 magic word", rd_data, w);
      else if (k == 1) chk("R4 info word", rd_data, w);
      else             chk("R6 R5 R3 body word", rd_data, w);
      @(posedge clk);
    end
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 count after last word", 32'(pend_cnt), 32'(c0) - 1);
  endtask

  task automatic do_flush();
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    cnt_wr = 1'b0;
    exp_q.delete(); tot_q.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready low after reset", 32'(in_ready), 32'd0);
    chk("R7 count zero after reset", 32'(pend_cnt), 32'd0);
    chk("R10 data zero after reset", rd_data, 32'd0);
    chk("R8 irq low after reset", 32'(rx_irq), 32'd0);
  endtask

  task automatic t_disabled();
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h55; in_last = 1'b1;
    repeat (5) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R1 ready low while disabled", 32'(in_ready), 32'd0);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk("R2 offered byte not stored", 32'(pend_cnt), 32'd0);
    rx_en = 1'b1;
    @(negedge clk);
    chk("R1 ready high once enabled", 32'(in_ready), 32'd1);
  endtask

  task automatic t_sizes();
    send_frame(10, 1);  read_frame();
    send_frame(1, 2);   read_frame();
    send_frame(60, 3);  read_frame();
    send_frame(61, 4);  read_frame();
    send_frame(63, 5);  read_frame();
  endtask

  task automatic t_queue();
    send_frame(13, 6);
    send_frame(64, 7);
    send_frame(70, 8);
    chk("R7 three pending", 32'(pend_cnt), 32'd3);
    read_frame(); read_frame(); read_frame();
  endtask

  task automatic t_empty_read();
    @(negedge clk);
    rd_en = 1'b1;
    chk("R10 empty read value", rd_data, 32'd0);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 empty read count", 32'(pend_cnt), 32'd0);
    send_frame(20, 9);
    read_frame();
  endtask

  task automatic t_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 irq cleared", 32'(rx_irq), 32'd0);
  endtask

  task automatic t_flush();
    send_frame(20, 10);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = 8'h05;
    @(posedge clk);
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R11 nonzero write ignored", 32'(pend_cnt), 32'd1);
    do_flush();
    chk("R11 flush clears count", 32'(pend_cnt), 32'd0);
    chk("R11 flush data zero", rd_data, 32'd0);
    send_frame(30, 11);
    read_frame();
  endtask

  task automatic t_room_wrap();
    do_flush();
    send_frame(1500, 12);
    @(negedge clk);
    chk("R1 ready with 2584 free", 32'(in_ready), 32'd1);
    send_frame(1500, 13);
    @(negedge clk);
    chk("R1 ready low with 1072 free", 32'(in_ready), 32'd0);
    read_frame();
    @(negedge clk);
    chk("R1 ready back after drain", 32'(in_ready), 32'd1);
    send_frame(1500, 14);
    read_frame();
    read_frame();
    chk("R12 wrapped frame drained", 32'(pend_cnt), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_sizes();
    t_queue();
    t_empty_read();
    t_irq();
    t_flush();
    t_room_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule